// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column side of a synchronous DRAM-style memory. It keeps the programmed operating mode and turns every read or write command into a stream of column addresses, one per clock. The mode holds the burst length, the ordering (linear or XOR-interleaved), the read latency and a switch that limits writes to one beat. For reads it produces a data-valid strobe that lags the burst by the programmed latency, plus per-byte output enables taken from the byte mask inputs. For writes it produces per-byte write enables in the same cycle as each beat.

Commands are decoded from four active-low strobes on the rising clock edge. The surrounding controller uses `beat_col` and `beat_bank` to address the array, `beat_wr` and `wr_be` to write, and `rd_valid` and `rd_oe` to time and gate read data on the shared bus. A full-page burst runs until a terminate or a new read or write command stops it.

Top module: `sdram_burst_seq`

## Requirements
- R1: Inputs are sampled only on the rising edge. The strobes {cs_n,ras_n,cas_n,we_n} decode as 0000 mode load, 0101 read, 0100 write and 0110 burst terminate; any other value does nothing. One clock after a read or write is sampled, `beat_valid` is 1, `beat_col` equals addr[8:0], `beat_bank` equals `ba` and `beat_wr` is 1 only for a write.
- R2: A mode load takes addr[2:0] as burst length (000=1, 001=2, 010=4, 011=8, 111=full page), addr[3] as ordering (1=interleave), addr[6:4] as read latency (010=2, 011=3) and addr[9] as single-write mode. After reset the mode is length 1, linear, latency 2, writes bursting.
- R3: A mode load that carries a reserved length code (100, 101, 110) or a reserved latency code leaves the whole mode unchanged.
- R4: In linear order, beat k of a burst of length L has column (start & ~(L-1)) | ((start + k) & (L-1)). After L beats `beat_valid` is 0.
- R5: In interleaved order, beat k has column (start & ~(L-1)) | ((start ^ k) & (L-1)).
- R6: A full-page burst steps the column by one per clock modulo 512 and does not end by itself. The ordering bit has no effect on it.
- R7: A burst terminate ends any burst: `beat_valid` is 0 one clock after it is sampled.
- R8: A read or write sampled during a burst replaces it. The next beat is beat 0 of the new command.
- R9: With single-write mode set, a write produces exactly one beat, while reads keep the programmed length.
- R10: `rd_valid` is high exactly CL clocks after each read beat is issued, where CL is the programmed latency. It is low for write beats.
- R11: For read data, the byte mask sampled at one edge applies to the data presented two clocks later. A set mask bit drives that byte's `rd_oe` bit low (dqm_lo is bit 0, dqm_hi is bit 1). `rd_oe` is 0 whenever `rd_valid` is 0.
- R12: During a write beat, `wr_be` is the inverse of the byte mask sampled at the same edge that issues the beat. `wr_be` is 0 in every other cycle.
- R13: While reset is high, all outputs go to 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Command select strobe, active low |
| ras_n | input | 1 | Command strobe, active low |
| cas_n | input | 1 | Command strobe, active low |
| we_n | input | 1 | Command strobe, active low |
| addr | input | ADDR_W (10) | Start column, or mode word on a mode load |
| ba | input | BANK_W (2) | Bank number captured with a read or write |
| dqm_lo | input | 1 | Lower byte mask |
| dqm_hi | input | 1 | Upper byte mask |
| beat_valid | output | 1 | A burst beat is issued this cycle |
| beat_wr | output | 1 | The current beat belongs to a write |
| beat_col | output | COL_W (9) | Column address of the current beat |
| beat_bank | output | BANK_W (2) | Bank of the current beat |
| wr_be | output | 2 | Per-byte write enable for the current beat |
| rd_valid | output | 1 | Read data valid, delayed by the latency |
| rd_oe | output | 2 | Per-byte read output enable |

## Verification
Two things can land on the same edge: a new read or write command can arrive while the latency pipeline is still delivering valid strobes for an earlier read. The bench triggers this by sending a write into the third beat of an eight-beat read at latency 3. It expects the new write's first beat on the very next clock, while `rd_valid` stays high for exactly the three read beats already issued and then drops. A terminate sent on the last observed beat of a full-page read is judged the same way: the beats stop at once, while the two strobes still in the pipeline drain.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_MODE  = 3'd1,
    C_READ  = 3'd2,
    C_WRITE = 3'd3,
    C_TERM  = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       ilv;
    logic       cl3;
    logic       wr_single;
  } mode_t;

  localparam mode_t MODE_RESET = '{bl_code: 3'b000, ilv: 1'b0, cl3: 1'b0, wr_single: 1'b0};

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = C_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  c = C_MODE;
        3'b101:  c = C_READ;
        3'b100:  c = C_WRITE;
        3'b110:  c = C_TERM;
        default: c = C_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [9:0] mode_word,
  output mode_t      mode
);

  logic [2:0] bl_f;
  logic [2:0] cl_f;
  logic       bl_ok;
  logic       cl_ok;
  logic       accept;

  assign bl_f   = mode_word[2:0];
  assign cl_f   = mode_word[6:4];
  assign bl_ok  = (bl_f[2] == 1'b0) || (bl_f == 3'b111);
  assign cl_ok  = (cl_f == 3'b010) || (cl_f == 3'b011);
  assign accept = load && bl_ok && cl_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_RESET;
    end else if (accept) begin
      mode.bl_code   <= bl_f;
      mode.ilv       <= mode_word[3];
      mode.cl3       <= cl_f[0];
      mode.wr_single <= mode_word[9];
    end
  end

  // R3
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !(bl_ok && cl_ok)) |=> $stable(mode));

  // R2
  latency_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    (load && bl_ok && cl_ok) |=> (mode.cl3 == $past(mode_word[4])));

endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [COL_W-1:0]  col_in,
  input  logic [BANK_W-1:0] ba_in,
  input  logic [1:0]        dqm,
  input  logic [2:0]        bl_code,
  input  logic              ilv,
  input  logic              wr_single,
  output logic              beat_valid,
  output logic              beat_wr,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic [1:0]        wr_be
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
    logic [COL_W-1:0] m;
    case (code)
      3'b000:  m = '0;
      3'b001:  m = COL_W'(1);
      3'b010:  m = COL_W'(3);
      3'b011:  m = COL_W'(7);
      default: m = ALL_ONES;
    endcase
    return m;
  endfunction

  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;

  logic             is_rw;
  logic             is_wr_cmd;
  logic             single_wr;
  logic             new_full;
  logic [COL_W-1:0] new_mask;
  logic [COL_W-1:0] idx_nx;
  logic [COL_W-1:0] step;
  logic [COL_W-1:0] col_nx;
  logic             last_beat;

  always_comb begin
    is_rw     = (cmd == C_READ) || (cmd == C_WRITE);
    is_wr_cmd = (cmd == C_WRITE);
    single_wr = is_wr_cmd && wr_single;
    new_full  = (bl_code == 3'b111) && !single_wr;
    new_mask  = single_wr ? '0 : len_mask(bl_code);
    idx_nx    = idx_q + COL_W'(1);
    step      = ilv_q ? (start_q ^ idx_nx) : (start_q + idx_nx);
    col_nx    = (start_q & ~mask_q) | (step & mask_q);
    last_beat = !full_q && (idx_q == mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_wr    <= 1'b0;
      beat_col   <= '0;
      beat_bank  <= '0;
      wr_be      <= '0;
      start_q    <= '0;
      idx_q      <= '0;
      mask_q     <= '0;
      full_q     <= 1'b0;
      ilv_q      <= 1'b0;
    end else if (is_rw) begin
      beat_valid <= 1'b1;
      beat_wr    <= is_wr_cmd;
      beat_col   <= col_in;
      beat_bank  <= ba_in;
      wr_be      <= is_wr_cmd ? ~dqm : 2'b00;
      start_q    <= col_in;
      idx_q      <= '0;
      mask_q     <= new_mask;
      full_q     <= new_full;
      ilv_q      <= ilv && !new_full;
    end else if (cmd == C_TERM) begin
      beat_valid <= 1'b0;
      wr_be      <= '0;
    end else if (beat_valid) begin
      if (last_beat) begin
        beat_valid <= 1'b0;
        wr_be      <= '0;
      end else begin
        idx_q    <= idx_nx;
        beat_col <= col_nx;
        wr_be    <= beat_wr ? ~dqm : 2'b00;
      end
    end else begin
      wr_be <= '0;
    end
  end

  // R7
  term_stops_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_TERM) |=> !beat_valid);

  // R9
  single_write_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_WRITE && wr_single) |=> (beat_valid && beat_wr));

  // R9
  single_write_end_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_wr && $past(cmd == C_WRITE && wr_single) && !is_rw) |=> !beat_valid);

  // R4
  block_held_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid) && !$past(is_rw)) |-> (((beat_col ^ $past(beat_col)) & ~mask_q) == '0));

  // R12
  wr_be_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_be != 2'b00) |-> (beat_valid && beat_wr));

endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe #(
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_beat,
  input  logic       cl3,
  input  logic [1:0] dqm,
  output logic       rd_valid,
  output logic [1:0] rd_oe
);

  localparam int DEPTH = MAX_CL - 1;

  logic [DEPTH-1:0] pipe_q;
  logic [1:0]       dm_q [MASK_LAT];
  logic             tap;

  always_ff @(posedge clk) begin
    if (rst) pipe_q[0] <= 1'b0;
    else     pipe_q[0] <= rd_beat;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) pipe_q[k] <= 1'b0;
        else     pipe_q[k] <= pipe_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dm_q[0] <= '0;
    else     dm_q[0] <= dqm;
  end

  generate
    for (genvar k = 1; k < MASK_LAT; k++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst) dm_q[k] <= '0;
        else     dm_q[k] <= dm_q[k-1];
      end
    end
  endgenerate

  assign tap = cl3 ? pipe_q[1] : pipe_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_oe    <= '0;
    end else begin
      rd_valid <= tap;
      rd_oe    <= tap ? ~dm_q[MASK_LAT-1] : 2'b00;
    end
  end

  // R10
  lat_two_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cl3) |-> (rd_valid == $past(rd_beat, 2)));

  // R10
  lat_three_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cl3) |-> (rd_valid == $past(rd_beat, 3)));

  // R11
  oe_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_oe != 2'b00) |-> rd_valid);

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] ba,
  input  logic              dqm_lo,
  input  logic              dqm_hi,
  output logic              beat_valid,
  output logic              beat_wr,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic [1:0]        wr_be,
  output logic              rd_valid,
  output logic [1:0]        rd_oe
);

  cmd_e       cmd;
  mode_t      mode;
  logic [1:0] dqm;
  logic       rd_beat;

  assign cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign dqm     = {dqm_hi, dqm_lo};
  assign rd_beat = beat_valid && !beat_wr;

  sdram_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd == C_MODE),
    .mode_word (addr[9:0]),
    .mode      (mode)
  );

  sdram_burst_ctr #(
    .COL_W  (COL_W),
    .BANK_W (BANK_W)
  ) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .col_in     (addr[COL_W-1:0]),
    .ba_in      (ba),
    .dqm        (dqm),
    .bl_code    (mode.bl_code),
    .ilv        (mode.ilv),
    .wr_single  (mode.wr_single),
    .beat_valid (beat_valid),
    .beat_wr    (beat_wr),
    .beat_col   (beat_col),
    .beat_bank  (beat_bank),
    .wr_be      (wr_be)
  );

  sdram_lat_pipe #(
    .MAX_CL   (MAX_CL),
    .MASK_LAT (2)
  ) u_lat (
    .clk      (clk),
    .rst      (rst),
    .rd_beat  (rd_beat),
    .cl3      (mode.cl3),
    .dqm      (dqm),
    .rd_valid (rd_valid),
    .rd_oe    (rd_oe)
  );

  // R1
  start_col_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_READ || cmd == C_WRITE) |=> (beat_valid && beat_col == $past(addr[COL_W-1:0]) && beat_bank == $past(ba)));

endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [1:0] ba = '0;
  logic       dqm_lo = 1'b0, dqm_hi = 1'b0;
  logic       beat_valid, beat_wr, rd_valid;
  logic [8:0] beat_col;
  logic [1:0] beat_bank, wr_be, rd_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_burst_seq dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .dqm_lo(dqm_lo), .dqm_hi(dqm_hi),
    .beat_valid(beat_valid), .beat_wr(beat_wr), .beat_col(beat_col),
    .beat_bank(beat_bank), .wr_be(wr_be), .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // 0 none, 1 mode, 2 read, 3 write, 4 terminate
  task automatic set_cmd(input int c);
    case (c)
      1:       {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      2:       {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      3:       {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      4:       {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    endcase
  endtask

  function automatic int pat(input int t, input int seed);
    return (t * 3 + seed) & 3;
  endfunction

  task automatic set_dqm(input int v);
    dqm_lo = v[0];
    dqm_hi = v[1];
  endtask

  task automatic mrs(input int bl, input int il, input int cl, input int wbm);
    @(negedge clk);
    set_cmd(1);
    addr = 10'((wbm << 9) | (cl << 4) | (il << 3) | bl);
    @(negedge clk);
    set_cmd(0);
  endtask

  task automatic run_burst(input bit wr, input int start, input int bank, input int len,
                           input int cl, input bit il, input string ord_tag, input int seed);
    int mask;
    int ecol;
    bit ev;
    bit erv;
    mask = len - 1;
    @(negedge clk);
    set_cmd(wr ? 3 : 2);
    addr = 10'(start);
    ba = 2'(bank);
    set_dqm(pat(0, seed));
    for (int j = 0; j <= len + cl + 1; j++) begin
      @(negedge clk);
      set_cmd(0);
      ev = (j < len);
      chk_eq(ev ? ord_tag : "R1 burst end", int'(beat_valid), int'(ev));
      if (ev) begin
        ecol = (start & ~mask & 511) | ((il ? (start ^ j) : (start + j)) & mask);
        chk_eq(ord_tag, int'(beat_col), ecol);
        chk_eq("R1 bank", int'(beat_bank), bank);
        chk_eq("R1 wr flag", int'(beat_wr), int'(wr));
      end
      chk_eq("R12 wr_be", int'(wr_be), (wr && ev) ? (~pat(j, seed) & 3) : 0);
      erv = !wr && (j >= cl) && (j - cl < len);
      chk_eq("R10 rd_valid", int'(rd_valid), int'(erv));
      chk_eq("R11 rd_oe", int'(rd_oe), erv ? (~pat(j - 2, seed) & 3) : 0);
      set_dqm(pat(j + 1, seed));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R13 reset state
    chk_eq("R13 beat_valid", int'(beat_valid), 0);
    chk_eq("R13 rd_valid", int'(rd_valid), 0);
    chk_eq("R13 wr_be", int'(wr_be), 0);
    chk_eq("R13 rd_oe", int'(rd_oe), 0);
    chk_eq("R13 beat_col", int'(beat_col), 0);
    rst = 1'b0;

    // R2 default mode: length 1, linear, latency 2
    run_burst(1'b0, 77, 2, 1, 2, 1'b0, "R2 default", 1);

    // R4 R5 R10 R11 read sweep
    for (int cl = 2; cl <= 3; cl++)
      for (int bl = 0; bl <= 3; bl++)
        for (int il = 0; il <= 1; il++) begin
          mrs(bl, il, cl, 0);
          for (int s = 0; s < 8; s++)
            run_burst(1'b0, 424 | s, s % 4, 1 << bl, cl, il[0], il != 0 ? "R5" : "R4", s);
        end

    // R12 write sweep
    for (int bl = 0; bl <= 3; bl++)
      for (int il = 0; il <= 1; il++) begin
        mrs(bl, il, 2, 0);
        for (int s = 0; s < 8; s += 3)
          run_burst(1'b1, 96 | s, 3 - (s % 4), 1 << bl, 2, il[0], il != 0 ? "R5 wr" : "R4 wr", s + 1);
      end

    // R9 single-write mode
    mrs(3, 0, 2, 1);
    run_burst(1'b1, 18, 1, 1, 2, 1'b0, "R9 write", 2);
    run_burst(1'b0, 18, 1, 8, 2, 1'b0, "R9 read", 2);

    // R3 reserved codes ignored: length 4 interleave latency 3 stays
    mrs(2, 1, 3, 0);
    mrs(5, 0, 2, 0);
    mrs(1, 0, 1, 0);
    run_burst(1'b0, 6, 0, 4, 3, 1'b1, "R3", 0);

    // R6 R7 full page read with ordering bit set, then terminate
    mrs(7, 1, 2, 0);
    @(negedge clk);
    set_cmd(2);
    addr = 10'd509;
    ba = 2'd3;
    set_dqm(0);
    for (int j = 0; j < 520; j++) begin
      @(negedge clk);
      set_cmd(0);
      if (j == 0 || j == 2 || j == 3 || j == 511 || j == 512 || j == 519) begin
        chk_eq("R6 valid", int'(beat_valid), 1);
        chk_eq("R6 col", int'(beat_col), (509 + j) % 512);
      end
      if (j == 519) set_cmd(4);
    end
    @(negedge clk);
    set_cmd(0);
    chk_eq("R7 stop", int'(beat_valid), 0);
    chk_eq("R7 drain1", int'(rd_valid), 1);
    @(negedge clk);
    chk_eq("R7 drain2", int'(rd_valid), 1);
    @(negedge clk);
    chk_eq("R7 drained", int'(rd_valid), 0);

    // R8 truncation: write lands in an 8-beat read at latency 3
    mrs(3, 0, 3, 0);
    @(negedge clk);
    set_cmd(2);
    addr = 10'd4;
    ba = 2'd1;
    set_dqm(0);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      set_cmd(0);
      if (j < 3) chk_eq("R8 old col", int'(beat_col), 4 + j);
      if (j >= 3 && j <= 10) begin
        chk_eq("R8 new valid", int'(beat_valid), 1);
        chk_eq("R8 new wr", int'(beat_wr), 1);
        chk_eq("R8 new col", int'(beat_col), 48 | ((51 + j - 3) & 7));
        chk_eq("R8 new bank", int'(beat_bank), 2);
      end
      if (j == 11) chk_eq("R8 new end", int'(beat_valid), 0);
      if (j >= 3) chk_eq("R8 rd_valid drain", int'(rd_valid), int'(j <= 5));
      if (j == 2) begin
        set_cmd(3);
        addr = 10'd51;
        ba = 2'd2;
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule